// File: doc/BRIEF.md
# Vectored Interrupt Controller for a Small Microcontroller Core

This block is the interrupt logic of a compact single-cycle processor core. Four interrupt sources feed it: the USB engine, a timer, an external pin and a GPIO bank. Each source event sets a sticky pending flag. Pending flags are gated first by per-source enables and then by one global enable. When the core reaches an instruction boundary and an enabled flag is pending, the block emits a one-cycle entry pulse. The pulse tells the program-counter logic to push the return address and to load the vector address that the block presents with it.

On entry the hardware drops the global enable, so no second interrupt nests. Flags stay set until software clears them. Software does this through a small register port that holds a control register (global and per-source enables) and a flag register. A return-from-interrupt input sets the global enable again and produces a one-cycle pop request for the stack. If software returns without clearing the flag that caused the entry, the same interrupt is taken again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, both registers read 0, all enables are off, and `vec_push` and `ret_pop` are low.
- R2: A high bit on `src_evt` sets the matching flag (bit 0 USB, bit 1 timer, bit 2 external, bit 3 GPIO) on the next edge. The global enable and the source enables do not affect this.
- R3: A flag is cleared only by a write to the flag register (`reg_sel`=1) with a 0 in its bit. Writing 1 leaves the bit unchanged. An event in the same cycle overrides the clear. Taking an interrupt leaves the flags as they are.
- R4: The control register (`reg_sel`=0) holds the global enable in bit 7 and the source enables in bits 3..0, in the same bit order as the flags. `reg_rdata` shows the register selected at the previous clock edge.
- R5: If `insn_boundary`, the global enable and at least one enabled pending flag are all true at a clock edge, `vec_push` is high for exactly the following cycle.
- R6: The vector presented with `vec_push` is 04h for USB, 08h for timer, 0Ch for external and 10h for GPIO. When several enabled flags are pending, the lowest vector wins.
- R7: Entry clears the global enable on the same edge that raises `vec_push`. No further entry happens until the global enable is set again.
- R8: `ret_req` sets the global enable and raises `ret_pop` for one cycle after that edge.
- R9: No entry happens without `insn_boundary`, with the global enable clear, or when no pending flag is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NSRC | Event pulses from the sources |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| ret_req | input | 1 | Return-from-interrupt executed |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| vec_push | output | 1 | Entry pulse: push return address and load vector |
| vec_addr | output | PC_W | Entry vector address |
| ret_pop | output | 1 | Pop request for the return address |

## Verification
If the flag state goes wrong, the read port shows it one cycle after selection. The vector port also shows it at the next instruction boundary, as a missing entry, an extra entry or the wrong vector. If the global enable is stuck high, a second entry pulse appears at the very next boundary after an entry while the flag is still pending. A broken priority chain shows as a wrong `vec_addr` in the same cycle as `vec_push` whenever two or more enabled flags are pending together. The bench walks these pending/enable patterns and then probes the boundary gating, the sticky-flag rules and the return path one cycle after each stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W   = 8;
  localparam int GIE_BIT = 7;
  typedef enum logic { SEL_CTRL = 1'b0, SEL_FLAG = 1'b1 } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_we,
  input  logic [NSRC-1:0] keep_mask,
  output logic [NSRC-1:0] flags
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                          flags[g] <= 1'b0;
      else if (evt[g])                  flags[g] <= 1'b1;
      else if (clr_we && !keep_mask[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NSRC-1:0]  req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int PC_W     = 13,
  parameter int IDX_W    = 2,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             ret_req,
  input  logic             gie_we,
  input  logic             gie_wdata,
  output logic             gie,
  output logic             vec_push,
  output logic [PC_W-1:0]  vec_addr,
  output logic             ret_pop
);
  logic [PC_W-1:0] vec_d;

  always_comb begin
    vec_d = PC_W'(VEC_BASE) + PC_W'(take_idx) * PC_W'(VEC_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie      <= 1'b0;
      vec_push <= 1'b0;
      ret_pop  <= 1'b0;
      vec_addr <= '0;
    end else begin
      vec_push <= take;
      ret_pop  <= ret_req;
      if (take) vec_addr <= vec_d;
      if (take)         gie <= 1'b0;
      else if (ret_req) gie <= 1'b1;
      else if (gie_we)  gie <= gie_wdata;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC     = 4,
  parameter int PC_W     = 13,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             insn_boundary,
  input  logic             ret_req,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             vec_push,
  output logic [PC_W-1:0]  vec_addr,
  output logic             ret_pop
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  flag_q;
  logic             gie_q;
  logic             ctrl_we;
  logic             flag_we;
  logic             pend_any;
  logic [IDX_W-1:0] pend_idx;
  logic             take;
  logic [REG_W-1:0] rd_d;
  logic             unused_wbits;

  assign ctrl_we      = reg_wr && (reg_sel == SEL_CTRL);
  assign flag_we      = reg_wr && (reg_sel == SEL_FLAG);
  assign unused_wbits = ^reg_wdata[GIE_BIT-1:NSRC];

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (ctrl_we) en_q <= reg_wdata[NSRC-1:0];
  end

  irq_flag_bank #(.NSRC(NSRC)) i_flags (
    .clk      (clk),
    .rst      (rst),
    .evt      (src_evt),
    .clr_we   (flag_we),
    .keep_mask(reg_wdata[NSRC-1:0]),
    .flags    (flag_q)
  );

  irq_prio_enc #(.NSRC(NSRC), .IDX_W(IDX_W)) i_prio (
    .req(flag_q & en_q),
    .any(pend_any),
    .idx(pend_idx)
  );

  assign take = insn_boundary && gie_q && pend_any;

  irq_seq #(
    .PC_W(PC_W), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) i_seq (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_idx (pend_idx),
    .ret_req  (ret_req),
    .gie_we   (ctrl_we),
    .gie_wdata(reg_wdata[GIE_BIT]),
    .gie      (gie_q),
    .vec_push (vec_push),
    .vec_addr (vec_addr),
    .ret_pop  (ret_pop)
  );

  always_comb begin
    rd_d = '0;
    if (reg_sel == SEL_FLAG) begin
      rd_d[NSRC-1:0] = flag_q;
    end else begin
      rd_d[NSRC-1:0] = en_q;
      rd_d[GIE_BIT]  = gie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int NSRC = 4,
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            insn_boundary,
  input logic            ret_req,
  input logic            reg_wr,
  input logic            reg_sel,
  input logic            vec_push,
  input logic [PC_W-1:0] vec_addr,
  input logic            ret_pop,
  input logic            gie,
  input logic [NSRC-1:0] flags
);
  p_push_single_r5: assert property (@(posedge clk) disable iff (rst)
    vec_push |=> !vec_push);

  p_push_gated_r9: assert property (@(posedge clk) disable iff (rst)
    vec_push |-> ($past(insn_boundary) && $past(gie)));

  p_vec_legal_r6: assert property (@(posedge clk) disable iff (rst)
    vec_push |-> (vec_addr == PC_W'(4) || vec_addr == PC_W'(8) ||
                  vec_addr == PC_W'(12) || vec_addr == PC_W'(16)));

  p_entry_masks_r7: assert property (@(posedge clk) disable iff (rst)
    vec_push |-> !gie);

  p_ret_pop_r8: assert property (@(posedge clk) disable iff (rst)
    ret_req |=> ret_pop);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr && reg_sel) |-> ((flags & $past(flags)) == $past(flags)));
endmodule

bind irq_vector_ctrl irq_vector_chk #(.NSRC(NSRC), .PC_W(PC_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .insn_boundary(insn_boundary),
  .ret_req      (ret_req),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .vec_push     (vec_push),
  .vec_addr     (vec_addr),
  .ret_pop      (ret_pop),
  .gie          (gie_q),
  .flags        (flag_q)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int NSRC = 4;
  localparam int PC_W = 13;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_evt = '0;
  logic            insn_boundary = 1'b0;
  logic            ret_req = 1'b0;
  logic            reg_wr = 1'b0;
  logic            reg_sel = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic            vec_push;
  logic [PC_W-1:0] vec_addr;
  logic            ret_pop;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl #(.NSRC(NSRC), .PC_W(PC_W)) i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .src_evt(src_evt), .insn_boundary(insn_boundary),
    .ret_req(ret_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_push(vec_push),
    .vec_addr(vec_addr), .ret_pop(ret_pop)
  );

  // {events[3:0], enables[3:0], taken, vector[5:0]}
  localparam logic [14:0] TBL [8] = '{
    {4'b0001, 4'b1111, 1'b1, 6'h04},
    {4'b0110, 4'b1111, 1'b1, 6'h08},
    {4'b1100, 4'b1111, 1'b1, 6'h0C},
    {4'b1000, 4'b1111, 1'b1, 6'h10},
    {4'b1111, 4'b1110, 1'b1, 6'h08},
    {4'b1111, 4'b1000, 1'b1, 6'h10},
    {4'b0101, 4'b1010, 1'b0, 6'h00},
    {4'b1111, 4'b0000, 1'b0, 6'h00}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    tick();
    d = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [NSRC-1:0] e);
    src_evt = e;
    tick();
    src_evt = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 push", {15'd0, vec_push}, 16'd0);
    chk("R1 pop", {15'd0, ret_pop}, 16'd0);
    rd(1'b0, r); chk("R1 R4 ctrl", {8'd0, r}, 16'h0000);
    rd(1'b1, r); chk("R1 flags", {8'd0, r}, 16'h0000);

    // table of priority / enable patterns (R5 R6 R9)
    for (int k = 0; k < 8; k++) begin
      wr(1'b1, 8'h00);
      wr(1'b0, {4'h8, TBL[k][10:7]});
      pulse_evt(TBL[k][14:11]);
      insn_boundary = 1'b1;
      tick();
      insn_boundary = 1'b0;
      chk("R5 R9 take", {15'd0, vec_push}, {15'd0, TBL[k][6]});
      if (TBL[k][6]) chk("R6 vector", 16'(vec_addr), {10'd0, TBL[k][5:0]});
      tick();
      chk("R5 pulse width", {15'd0, vec_push}, 16'd0);
      if (TBL[k][6]) begin
        ret_req = 1'b1;
        tick();
        ret_req = 1'b0;
        chk("R8 pop", {15'd0, ret_pop}, 16'd1);
      end
    end
    wr(1'b1, 8'h00);

    // R2 flags latch with global enable off; R9 no entry
    wr(1'b0, 8'h0F);
    pulse_evt(4'b0100);
    insn_boundary = 1'b1;
    tick();
    insn_boundary = 1'b0;
    chk("R9 gie off", {15'd0, vec_push}, 16'd0);
    rd(1'b1, r); chk("R2 flag latched", {8'd0, r}, 16'h0004);

    // R3 writing 1 keeps, writing 0 clears
    wr(1'b1, 8'hFF);
    rd(1'b1, r); chk("R3 write one", {8'd0, r}, 16'h0004);
    wr(1'b1, 8'hFB);
    rd(1'b1, r); chk("R3 write zero", {8'd0, r}, 16'h0000);

    // R9 boundary gating, then entry R5 R6 R7
    pulse_evt(4'b0010);
    wr(1'b0, 8'h8F);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9 no boundary", {15'd0, vec_push}, 16'd0);
    end
    insn_boundary = 1'b1;
    tick();
    insn_boundary = 1'b0;
    chk("R5 entry", {15'd0, vec_push}, 16'd1);
    chk("R6 timer vector", 16'(vec_addr), 16'h0008);
    rd(1'b0, r); chk("R7 gie cleared", {8'd0, r}, 16'h000F);
    rd(1'b1, r); chk("R3 entry keeps flag", {8'd0, r}, 16'h0002);
    insn_boundary = 1'b1;
    tick();
    chk("R7 no nesting", {15'd0, vec_push}, 16'd0);
    tick();
    chk("R7 no nesting 2", {15'd0, vec_push}, 16'd0);
    insn_boundary = 1'b0;

    // R8 return, R3 repeat when flag not cleared
    ret_req = 1'b1;
    tick();
    ret_req = 1'b0;
    chk("R8 pop pulse", {15'd0, ret_pop}, 16'd1);
    tick();
    chk("R8 pop ends", {15'd0, ret_pop}, 16'd0);
    rd(1'b0, r); chk("R8 gie set", {8'd0, r}, 16'h008F);
    insn_boundary = 1'b1;
    tick();
    insn_boundary = 1'b0;
    chk("R3 repeat entry", {15'd0, vec_push}, 16'd1);
    chk("R3 repeat vector", 16'(vec_addr), 16'h0008);
    ret_req = 1'b1;
    tick();
    ret_req = 1'b0;
    wr(1'b1, 8'h00);

    // R3 event beats clear in the same cycle
    src_evt = 4'b0001;
    wr(1'b1, 8'h00);
    src_evt = '0;
    rd(1'b1, r); chk("R3 event over clear", {8'd0, r}, 16'h0001);

    finish_run();
  end
endmodule